// File: doc/BRIEF.md
# Receive Queue Slot Index Manager

This block keeps the bookkeeping for a circular receive queue whose entries are message-buffer slots. The slots form one contiguous range, given by a programmable first index and a slot count. The block tracks how many entries are held, which slot holds the oldest entry (the read index) and which slot the next accepted frame goes to (the write index). When a frame arrives as a single-cycle strobe and there is room, the block signals the store and presents the target slot in the same cycle.

Software frees entries in bulk. It writes a pop count, and the block releases that many of the oldest entries. If the count is larger than the number held, the block limits it to the number held and gives no indication. Two sticky flags report events. The first is a queue-filling warning, raised by a watermark crossing on a store or by a periodic timer tick while the queue holds data. The second is a lost-frame error, raised when a frame arrives while every slot is in use. Each flag is cleared by its own clear strobe. The frame storage, frame acceptance filtering and the bus side are handled outside this block.

Top module: `rxq_index_mgr`

## Requirements
- R1: After reset the fill level, read index and write index are 0, both flags are 0 and `wr_en` is 0.
- R2: A cycle with `cfg_wr` high loads `cfg_start` and `cfg_depth`. On the next cycle both indices equal `cfg_start` and the fill level is 0. In that cycle frame, pop, timer and clear inputs have no effect, and both flags hold their values.
- R3: A frame strobe that arrives when the fill level is below the depth drives `wr_en` high in the same cycle, with `wr_idx` naming the target slot. On the next cycle the fill level has gone up by one and `wr_idx` has advanced by one slot.
- R4: Either index that steps past slot start+depth−1 continues from the start index.
- R5: A frame strobe that arrives when the fill level equals the depth is dropped. `wr_en` stays 0, the write index and fill level are unchanged, and the lost-frame flag is set.
- R6: A pop write with a nonzero count c removes min(c, fill) of the oldest entries, and the read index advances by that same number.
- R7: A pop count above the fill level empties the queue, and no flag is raised.
- R8: A pop write with a count of 0 changes neither the fill level nor the read index.
- R9: A store sets the filling flag when the updated fill level is strictly greater than `cfg_wmark`. A fill level equal to the watermark does not set it.
- R10: A timer tick sets the filling flag when the fill level before the tick is nonzero. A tick on an empty queue does nothing.
- R11: `clr_af` and `clr_ovf` clear their flag on the next cycle. A setting event in the same cycle takes priority over the clear.
- R12: When a store and a pop occur in the same cycle, the new fill level is old+1−min(c, old). The room check uses the old fill level, so a frame that meets a full queue is still dropped, even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load range configuration and empty the queue |
| cfg_start | input | IDX_W | First slot index of the range |
| cfg_depth | input | IDX_W+1 | Number of slots in the range |
| cfg_wmark | input | IDX_W+1 | Fill level that the warning must exceed |
| frame_vld | input | 1 | One-cycle strobe: accepted frame arriving |
| tmr_expire | input | 1 | One-cycle periodic timer tick |
| pop_wr | input | 1 | Pop count write strobe |
| pop_cnt | input | IDX_W+1 | Number of entries to release |
| clr_af | input | 1 | Clear the filling warning flag |
| clr_ovf | input | 1 | Clear the lost-frame flag |
| wr_en | output | 1 | Frame is stored this cycle at `wr_idx` |
| wr_idx | output | IDX_W | Slot for the next stored frame |
| rd_idx | output | IDX_W | Slot of the oldest held entry |
| fill_lvl | output | IDX_W+1 | Number of entries held |
| af_flag | output | 1 | Sticky queue-filling warning |
| ovf_flag | output | 1 | Sticky lost-frame error |

## Verification
All state is held in registers that drive the ports directly, so a wrong fill count or a wrong index is visible at `fill_lvl`, `rd_idx` or `wr_idx` one cycle after the event that caused it. An error in the wrap arithmetic shows at the first crossing of the range end, as an index outside the range. An error in pop saturation shows as a fill level above zero, or a wrapped-around fill level, right after an oversized pop. A wrong room check shows in the same cycle as `wr_en` asserted on a full queue, and one cycle later as a missing lost-frame flag.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    // Default slot index width for the queue range
    localparam int unsigned RXQ_IDX_W_DEF = 6;

    // Sticky event flags kept by the manager
    typedef struct packed {
        logic af;   // queue filling warning
        logic ovf;  // frame lost on full queue
    } rxq_flags_t;
endpackage

// File: rtl/rxq_idx_wrap.sv
`timescale 1ns/1ps
// Advances a slot index by a step inside [start, start+depth-1], wrapping.
module rxq_idx_wrap #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] start,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] step,
    output logic [IDX_W-1:0] nxt
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [IDX_W-1:0] rel;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] folded;

    always_comb begin
        rel    = idx - start;
        sum    = SUM_W'(rel) + SUM_W'(step);
        folded = (sum >= SUM_W'(depth)) ? (sum - SUM_W'(depth)) : sum;
        nxt    = start + folded[IDX_W-1:0];
    end
endmodule

// File: rtl/rxq_pop_sat.sv
`timescale 1ns/1ps
// Limits a requested release count to the number of entries held.
module rxq_pop_sat #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] removed
);
    always_comb begin
        if (!req)
            removed = '0;
        else if (cnt > fill)
            removed = fill;
        else
            removed = cnt;
    end
endmodule

// File: rtl/rxq_index_mgr.sv
`timescale 1ns/1ps
module rxq_index_mgr #(
    parameter int unsigned IDX_W = rxq_pkg::RXQ_IDX_W_DEF,
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_start,
    input  logic [CNT_W-1:0] cfg_depth,
    input  logic [CNT_W-1:0] cfg_wmark,
    input  logic             frame_vld,
    input  logic             tmr_expire,
    input  logic             pop_wr,
    input  logic [CNT_W-1:0] pop_cnt,
    input  logic             clr_af,
    input  logic             clr_ovf,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] fill_lvl,
    output logic             af_flag,
    output logic             ovf_flag
);
    import rxq_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] start;
        logic [CNT_W-1:0] depth;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] wr;
        logic [CNT_W-1:0] fill;
        rxq_flags_t       flags;
    } rxq_state_t;

    rxq_state_t st_d, st_q;

    logic             room;
    logic             store;
    logic [CNT_W-1:0] removed;
    logic [IDX_W-1:0] rd_step_nxt;
    logic [IDX_W-1:0] wr_step_nxt;
    logic [CNT_W-1:0] fill_new;
    logic             af_set;
    logic             ovf_set;

    rxq_pop_sat #(.CNT_W(CNT_W)) pop_sat_i (
        .req     (pop_wr),
        .cnt     (pop_cnt),
        .fill    (st_q.fill),
        .removed (removed)
    );

    rxq_idx_wrap #(.IDX_W(IDX_W), .CNT_W(CNT_W)) rd_wrap_i (
        .idx   (st_q.rd),
        .start (st_q.start),
        .depth (st_q.depth),
        .step  (removed),
        .nxt   (rd_step_nxt)
    );

    rxq_idx_wrap #(.IDX_W(IDX_W), .CNT_W(CNT_W)) wr_wrap_i (
        .idx   (st_q.wr),
        .start (st_q.start),
        .depth (st_q.depth),
        .step  (CNT_W'(1)),
        .nxt   (wr_step_nxt)
    );

    always_comb begin
        st_d     = st_q;
        room     = st_q.fill < st_q.depth;
        store    = frame_vld && room && !cfg_wr;
        fill_new = st_q.fill + CNT_W'(store) - removed;
        af_set   = (store && (fill_new > cfg_wmark)) ||
                   (tmr_expire && (st_q.fill != '0));
        ovf_set  = frame_vld && !room;

        if (cfg_wr) begin
            // New range: empty the queue, leave flags untouched
            st_d.start = cfg_start;
            st_d.depth = cfg_depth;
            st_d.rd    = cfg_start;
            st_d.wr    = cfg_start;
            st_d.fill  = '0;
        end else begin
            st_d.fill = fill_new;
            st_d.rd   = rd_step_nxt;
            if (store)
                st_d.wr = wr_step_nxt;
            // Clear first, so a same-cycle set wins
            if (clr_af)
                st_d.flags.af = 1'b0;
            if (clr_ovf)
                st_d.flags.ovf = 1'b0;
            if (af_set)
                st_d.flags.af = 1'b1;
            if (ovf_set)
                st_d.flags.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_en    = store;
    assign wr_idx   = st_q.wr;
    assign rd_idx   = st_q.rd;
    assign fill_lvl = st_q.fill;
    assign af_flag  = st_q.flags.af;
    assign ovf_flag = st_q.flags.ovf;
endmodule

// File: rtl/rxq_index_mgr_chk.sv
`timescale 1ns/1ps
module rxq_index_mgr_chk #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             frame_vld,
    input  logic             tmr_expire,
    input  logic             pop_wr,
    input  logic [CNT_W-1:0] pop_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] fill_lvl,
    input  logic [CNT_W-1:0] depth,
    input  logic             af_flag,
    input  logic             ovf_flag
);
    // R2
    cfg_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (fill_lvl == '0) && (rd_idx == wr_idx));

    // R3
    wr_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fill_lvl < depth));

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= depth);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !cfg_wr && (fill_lvl == depth)) |=> ovf_flag);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !cfg_wr && !pop_wr && (fill_lvl == depth))
        |=> ($stable(fill_lvl) && $stable(wr_idx)));

    // R7
    pop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_wr && (pop_cnt >= fill_lvl) && !frame_vld && !cfg_wr)
        |=> (fill_lvl == '0));

    // R8
    pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_wr && (pop_cnt == '0) && !frame_vld && !cfg_wr)
        |=> ($stable(fill_lvl) && $stable(rd_idx)));

    // R10
    af_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire && !cfg_wr && (fill_lvl != '0)) |=> af_flag);
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .frame_vld  (frame_vld),
    .tmr_expire (tmr_expire),
    .pop_wr     (pop_wr),
    .pop_cnt    (pop_cnt),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .fill_lvl   (fill_lvl),
    .depth      (st_q.depth),
    .af_flag    (af_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/rxq_index_mgr_tb_top.sv
`timescale 1ns/1ps
module rxq_index_mgr_tb_top;
    localparam int unsigned IDX_W = 6;
    localparam int unsigned CNT_W = IDX_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [IDX_W-1:0] cfg_start = '0;
    logic [CNT_W-1:0] cfg_depth = '0;
    logic [CNT_W-1:0] cfg_wmark = '0;
    logic             frame_vld = 1'b0;
    logic             tmr_expire = 1'b0;
    logic             pop_wr = 1'b0;
    logic [CNT_W-1:0] pop_cnt = '0;
    logic             clr_af = 1'b0;
    logic             clr_ovf = 1'b0;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] fill_lvl;
    logic             af_flag;
    logic             ovf_flag;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    rxq_index_mgr #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_depth(cfg_depth), .cfg_wmark(cfg_wmark), .frame_vld(frame_vld),
        .tmr_expire(tmr_expire), .pop_wr(pop_wr), .pop_cnt(pop_cnt),
        .clr_af(clr_af), .clr_ovf(clr_ovf), .wr_en(wr_en), .wr_idx(wr_idx),
        .rd_idx(rd_idx), .fill_lvl(fill_lvl), .af_flag(af_flag), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [7:0]       req;
        logic             frm;
        logic             tmr;
        logic             pw;
        logic [CNT_W-1:0] pc;
        logic             caf;
        logic             covf;
        logic [CNT_W-1:0] e_fill;
        logic [IDX_W-1:0] e_rd;
        logic [IDX_W-1:0] e_wr;
        logic             e_af;
        logic             e_ovf;
    } vec_t;

    // Range: start 10, depth 4 (slots 10..13), watermark 2
    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'd3,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd1,6'd10,6'd11,1'b0,1'b0}, // R3 store
        '{8'd9,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd2,6'd10,6'd12,1'b0,1'b0}, // R9 equal no set
        '{8'd9,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd3,6'd10,6'd13,1'b1,1'b0}, // R9 above sets
        '{8'd11, 1'b0,1'b0,1'b0,7'd0,1'b1,1'b0, 7'd3,6'd10,6'd13,1'b0,1'b0}, // R11 clear
        '{8'd4,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd4,6'd10,6'd10,1'b1,1'b0}, // R4 wr wraps
        '{8'd5,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd4,6'd10,6'd10,1'b1,1'b1}, // R5 full drop
        '{8'd11, 1'b0,1'b0,1'b0,7'd0,1'b1,1'b1, 7'd4,6'd10,6'd10,1'b0,1'b0}, // R11 both clear
        '{8'd6,  1'b0,1'b0,1'b1,7'd3,1'b0,1'b0, 7'd1,6'd13,6'd10,1'b0,1'b0}, // R6 pop 3
        '{8'd10, 1'b0,1'b1,1'b0,7'd0,1'b0,1'b0, 7'd1,6'd13,6'd10,1'b1,1'b0}, // R10 tick
        '{8'd11, 1'b0,1'b1,1'b0,7'd0,1'b1,1'b0, 7'd1,6'd13,6'd10,1'b1,1'b0}, // R11 set wins
        '{8'd12, 1'b1,1'b0,1'b1,7'd1,1'b0,1'b0, 7'd1,6'd10,6'd11,1'b1,1'b0}, // R12 store+pop, R4 rd wraps
        '{8'd11, 1'b0,1'b0,1'b0,7'd0,1'b1,1'b0, 7'd1,6'd10,6'd11,1'b0,1'b0}, // R11
        '{8'd7,  1'b0,1'b0,1'b1,7'd5,1'b0,1'b0, 7'd0,6'd11,6'd11,1'b0,1'b0}, // R7 saturate
        '{8'd10, 1'b0,1'b1,1'b0,7'd0,1'b0,1'b0, 7'd0,6'd11,6'd11,1'b0,1'b0}, // R10 empty tick
        '{8'd3,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd1,6'd11,6'd12,1'b0,1'b0}, // R3
        '{8'd8,  1'b0,1'b0,1'b1,7'd0,1'b0,1'b0, 7'd1,6'd11,6'd12,1'b0,1'b0}, // R8 pop zero
        '{8'd3,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd2,6'd11,6'd13,1'b0,1'b0}, // R3
        '{8'd9,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd3,6'd11,6'd10,1'b1,1'b0}, // R9
        '{8'd3,  1'b1,1'b0,1'b0,7'd0,1'b0,1'b0, 7'd4,6'd11,6'd11,1'b1,1'b0}, // R3 now full
        '{8'd12, 1'b1,1'b0,1'b1,7'd1,1'b0,1'b0, 7'd3,6'd12,6'd11,1'b1,1'b1}  // R12 full drop + pop
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int f, input int r, input int w,
                           input int a, input int o);
        chk(req, "fill_lvl", int'(fill_lvl), f);
        chk(req, "rd_idx",   int'(rd_idx),   r);
        chk(req, "wr_idx",   int'(wr_idx),   w);
        chk(req, "af_flag",  int'(af_flag),  a);
        chk(req, "ovf_flag", int'(ovf_flag), o);
    endtask

    task automatic idle_inputs();
        cfg_wr = 1'b0; frame_vld = 1'b0; tmr_expire = 1'b0;
        pop_wr = 1'b0; pop_cnt = '0; clr_af = 1'b0; clr_ovf = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_all("R1", 0, 0, 0, 0, 0);
        chk("R1", "wr_en", int'(wr_en), 0);

        // R2 configure range 10..13
        cfg_start = 6'd10; cfg_depth = 7'd4; cfg_wmark = 7'd2; cfg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk_all("R2", 0, 10, 10, 0, 0);

        for (int i = 0; i < NV; i++) begin
            frame_vld = VEC[i].frm; tmr_expire = VEC[i].tmr;
            pop_wr = VEC[i].pw; pop_cnt = VEC[i].pc;
            clr_af = VEC[i].caf; clr_ovf = VEC[i].covf;
            @(posedge clk); @(negedge clk);
            idle_inputs();
            chk_all($sformatf("R%0d vec%0d", VEC[i].req, i), int'(VEC[i].e_fill),
                    int'(VEC[i].e_rd), int'(VEC[i].e_wr), int'(VEC[i].e_af),
                    int'(VEC[i].e_ovf));
        end

        // State now: fill 3, rd 12, wr 11, af 1, ovf 1
        // R3 same-cycle store strobe and slot
        frame_vld = 1'b1;
        #2;
        chk("R3", "wr_en", int'(wr_en), 1);
        chk("R3", "wr_idx", int'(wr_idx), 11);
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R3", "fill_lvl", int'(fill_lvl), 4);
        chk("R3", "wr_idx", int'(wr_idx), 12);

        // R5 no store strobe on full queue
        frame_vld = 1'b1;
        #2;
        chk("R5", "wr_en", int'(wr_en), 0);
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R5", "fill_lvl", int'(fill_lvl), 4);
        chk("R5", "wr_idx", int'(wr_idx), 12);

        // R2 reconfigure with competing inputs; flags hold
        cfg_start = 6'd40; cfg_depth = 7'd8; cfg_wr = 1'b1;
        frame_vld = 1'b1; pop_wr = 1'b1; pop_cnt = 7'd2;
        clr_af = 1'b1; clr_ovf = 1'b1; tmr_expire = 1'b1;
        #2;
        chk("R2", "wr_en", int'(wr_en), 0);
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk_all("R2", 0, 40, 40, 1, 1);

        summary();
    end
endmodule